// File: doc/BRIEF.md
# Port Pin Interrupt Detector

This block watches a group of general-purpose input pins and turns activity on them into a single interrupt request. Each pin has an enable input and a polarity input. The enable decides whether the pin takes part. The polarity decides whether a rising edge or high level counts as active, or a falling edge or low level does. Every pin passes through a two-flop synchronizer. The active conditions of all enabled pins are then ORed into one detect signal for the whole port.

One 8-bit status and control register is reachable over a simple write strobe with a combinational read. It holds an interrupt enable bit and a detect-mode bit. It also shows a sticky flag, and it has an acknowledge bit that is write-only. In edge mode only an inactive-to-active transition sets the flag. In edge-and-level mode, an active level that is held also sets the flag, and it keeps the flag from clearing. The flag is a two-state machine with states `ST_CLEAR` and `ST_PENDING`. Transition `T_DETECT` goes from `ST_CLEAR` to `ST_PENDING` when detect is high. Transition `T_ACK` goes from `ST_PENDING` to `ST_CLEAR` when an acknowledge write arrives and detect is low. In every other cycle the machine stays in its state.

Top module: `port_irq_detect`

## Requirements
- R1: After reset, the register reads 8'h00 and `irq` is 0.
- R2: Register bits 7:4 and bit 2 (acknowledge) always read as 0, even after 1s are written to them.
- R3: A write to bit 3 (flag) has no effect. The flag changes only through detection or acknowledge.
- R4: A pin change is sampled by two synchronizer flops. The flag therefore reads 1 after the third rising clock edge that follows the pin change.
- R5: With a polarity bit of 1, only a rising edge or high level is active. With a polarity bit of 0, only a falling edge or low level is active. An edge of the opposite direction does not set the flag.
- R6: A pin whose enable bit is 0 never sets the flag, whatever it does.
- R7: With mode bit 0 set to 0 (edge mode), an active level that stays held after an acknowledge does not set the flag again.
- R8: With mode bit 0 set to 1 (edge-and-level mode), a held active level sets the flag, and an acknowledge does not clear the flag while that level is present.
- R9: Writing 1 to bit 2 clears the flag on the next edge, provided no detection is present in that cycle.
- R10: If a detection and an acknowledge write fall in the same cycle, the flag stays 1.
- R11: `irq` equals flag AND enable bit 1. With bit 1 at 0 the flag may still set, but `irq` stays 0.
- R12: Any single enabled pin, at any position, is enough to set the one shared flag.
- R13: Bits 1:0 take the written value on the edge that follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: {0000, flag, 0, enable, mode} |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_en | input | NPINS | Per-pin participation enable |
| pin_pol | input | NPINS | Per-pin polarity: 1 rising/high, 0 falling/low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands in exactly the cycle in which a fresh edge reaches the detector, three clocks after the pin moved. To create it, the stimulus changes a pin and then idles for a counted number of cycles so that the acknowledge lands on that edge. A second hard case is an acknowledge made while a level is still held in level mode. Here the pin is kept active across the write, and the stimulus then releases it and waits for the synchronizer to drain before it acknowledges again. The behavioural model in the bench predicts every one of these cycles on its own.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_MODE = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_ACK  = 2;
    localparam int BIT_FLAG = 3;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_PENDING = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] smp_now,
    output logic [NPINS-1:0] smp_prev
);
    genvar gi;
    generate
        for (gi = 0; gi < NPINS; gi++) begin : g_pin
            logic meta_q, sync_q, prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pin_in[gi];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign smp_now[gi]  = sync_q;
            assign smp_prev[gi] = prev_q;
        end
    endgenerate
endmodule

// File: rtl/pin_detect.sv
module pin_detect #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] smp_now,
    input  logic [NPINS-1:0] smp_prev,
    input  logic [NPINS-1:0] pin_en,
    input  logic [NPINS-1:0] pin_pol,
    input  logic             level_mode,
    output logic             detect_any
);
    logic [NPINS-1:0] act_now;
    logic [NPINS-1:0] edge_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NPINS; gi++) begin : g_det
            logic act_prev;
            assign act_now[gi]  = pin_en[gi] & (smp_now[gi] == pin_pol[gi]);
            assign act_prev     = pin_en[gi] & (smp_prev[gi] == pin_pol[gi]);
            assign edge_hit[gi] = act_now[gi] & ~act_prev;
        end
    endgenerate

    assign detect_any = (|edge_hit) | (level_mode & (|act_now));
endmodule

// File: rtl/flag_fsm.sv
module flag_fsm
    import port_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic detect,
    input  logic ack,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:   if (detect) state_d = ST_PENDING;          // T_DETECT
            ST_PENDING: if (ack && !detect) state_d = ST_CLEAR;    // T_ACK
            default:    state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_PENDING: flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import port_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       wr_ie,
    input  logic       wr_mode,
    input  logic       flag,
    output logic       ie,
    output logic       mode,
    output logic [REG_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            mode <= 1'b0;
        end else if (wr) begin
            ie   <= wr_ie;
            mode <= wr_mode;
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[BIT_FLAG] = flag;
        rdata[BIT_IE]   = ie;
        rdata[BIT_MODE] = mode;
    end
endmodule

// File: rtl/port_irq_detect.sv
module port_irq_detect
    import port_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_en,
    input  logic [NPINS-1:0] pin_pol,
    output logic             irq
);
    logic [NPINS-1:0] smp_now, smp_prev;
    logic detect_any, flag, ie, mode, ack;

    assign ack = reg_wr & reg_wdata[BIT_ACK];

    pin_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .smp_now(smp_now), .smp_prev(smp_prev)
    );

    pin_detect #(.NPINS(NPINS)) u_det (
        .smp_now(smp_now), .smp_prev(smp_prev), .pin_en(pin_en),
        .pin_pol(pin_pol), .level_mode(mode), .detect_any(detect_any)
    );

    flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .detect(detect_any), .ack(ack), .flag(flag)
    );

    ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr),
        .wr_ie(reg_wdata[BIT_IE]), .wr_mode(reg_wdata[BIT_MODE]),
        .flag(flag), .ie(ie), .mode(mode), .rdata(reg_rdata)
    );

    assign irq = flag & ie;
endmodule

// File: rtl/port_irq_detect_chk.sv
module port_irq_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       irq,
    input logic       det
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7:4] == 4'h0) && !reg_rdata[2]);

    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (reg_rdata[3] & reg_rdata[1]));

    a_r10_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> reg_rdata[3]);

    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[3] && !det) |=> !reg_rdata[3]);

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[2] && !det) |=> !reg_rdata[3]);

    a_r13_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[1:0] == $past(reg_wdata[1:0])));
endmodule

bind port_irq_detect port_irq_detect_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .det(detect_any)
);

// File: tb/port_irq_detect_tb.sv
`timescale 1ns/1ps
module port_irq_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 8'h00, pin_en = 8'h00, pin_pol = 8'h00;
    logic       irq;

    int checks = 0, fails = 0;
    bit m_flag = 0, m_ie = 0, m_mode = 0;
    logic [7:0] hist[$];
    string tag = "R1";

    always #4 clk = ~clk;

    port_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_en(pin_en),
        .pin_pol(pin_pol), .irq(irq)
    );

    task automatic check(input logic [7:0] got_r, input logic got_i);
        logic [7:0] exp_r;
        exp_r = {4'h0, m_flag, 1'b0, m_ie, m_mode};
        checks++;
        if (got_r !== exp_r || got_i !== (m_flag & m_ie)) begin
            fails++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, got_r, got_i, exp_r, m_flag & m_ie);
        end
    endtask

    // Behavioural model: pin seen by the detector is the one applied two
    // edges earlier; "previous" is three edges earlier.
    task automatic model_edge();
        logic [7:0] a2, a3;
        bit det, ack;
        a2  = pin_en & ~(hist[1] ^ pin_pol);
        a3  = pin_en & ~(hist[2] ^ pin_pol);
        det = (|(a2 & ~a3)) || (m_mode && (|a2));
        ack = reg_wr && reg_wdata[2];
        if (det)      m_flag = 1;
        else if (ack) m_flag = 0;
        if (reg_wr) begin m_ie = reg_wdata[1]; m_mode = reg_wdata[0]; end
        hist.push_front(pin_in);
        void'(hist.pop_back());
    endtask

    task automatic step(input bit wr, input logic [7:0] wd);
        reg_wr = wr; reg_wdata = wd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        reg_wr = 0; reg_wdata = 8'h00;
        check(reg_rdata, irq);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00);
    endtask

    initial begin
        #(8 * 5000);
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        hist = '{8'h00, 8'h00, 8'h00};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tag = "R1"; check(reg_rdata, irq);

        // R2 / R3: reserved, ack and flag bits written with 1s
        tag = "R2 R3"; step(1, 8'hFC); idle(3);

        // R4 / R5 / R12: rising edge on pin 5, polarity high
        tag = "R4 R5 R12"; pin_en = 8'h20; pin_pol = 8'h20;
        idle(2); pin_in = 8'h20; idle(4);

        // R11: enable request while flag pending
        tag = "R11"; step(1, 8'h02); idle(1);

        // R9 / R7: ack in edge mode with level still held
        tag = "R9 R7"; step(1, 8'h06); idle(4);

        // R5: opposite-direction edge on pin 0 with falling polarity
        tag = "R5"; pin_en = 8'h21; pin_pol = 8'h20; pin_in = 8'h21; idle(4);
        pin_in = 8'h20; idle(4);  // falling edge: active
        step(1, 8'h06); idle(2);

        // R6: disabled pin toggles
        tag = "R6"; pin_en = 8'h00;
        for (int k = 0; k < 6; k++) begin pin_in = pin_in ^ 8'h81; idle(2); end

        // R8: level mode with held active level
        tag = "R8"; pin_in = 8'h00; pin_en = 8'h02; pin_pol = 8'h00;
        idle(4); step(1, 8'h03); idle(3);
        step(1, 8'h07); idle(2);
        pin_in = 8'h02; idle(4);
        step(1, 8'h07); idle(3);

        // R10: edge detect coincident with acknowledge
        tag = "R10"; step(1, 8'h02); pin_en = 8'h04; pin_pol = 8'h04;
        pin_in = 8'h06; idle(4);        // flag set by pin 2 rise
        step(1, 8'h06); idle(1);        // cleared
        pin_in = 8'h02; idle(3);
        pin_in = 8'h06; idle(2);        // edge reaches detector next edge
        step(1, 8'h06);                 // ack in same cycle
        idle(2);
        step(1, 8'h06); idle(2);

        // R13: control bit writes
        tag = "R13"; step(1, 8'h01); step(1, 8'h02); step(1, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule